// File: doc/BRIEF.md
# Crystal Fault Fail-Safe Clock Selector

This block chooses the source of two clocks: the reference that feeds the frequency-locked loop and the auxiliary clock. Each can come from an external low-frequency crystal or from an internal reference oscillator. It watches the crystal for missing edges and for a disabled pin mode. A detected fault raises a sticky crystal fault flag. While that flag is set, both clocks run from the internal oscillator. A clock goes back to the crystal only after software clears the flag, even if the crystal has been running again for a long time.

A DCO fault arrives as an input and is held in its own sticky flag. An aggregate oscillator interrupt flag is raised again in every cycle in which either source flag is set. Software therefore clears the source flags first, then clears the aggregate flag, and re-tests until the aggregate flag stays clear. All flag and control state sits in the `clk` domain and is written through a single-cycle write strobe. Flag clears are write-one-to-clear. Each output clock is switched by a glitch-free handoff between the two source clocks.

Top module: `xtal_failsafe_clksel`

## Requirements
- R1: While reset is asserted and just after it: crystal flag = 1, DCO flag = 0, aggregate flag = 1, interrupt = 0, control = 3'b011, and both clock outputs are held low. Once reset is released, both clocks start from the internal oscillator.
- R2: The crystal flag is set when TMO_CYC (8) rising edges of the internal oscillator pass with no crystal rising edge, or while `xt_pin_en` is low. A crystal that is slower but still has a rising edge within that window raises no fault.
- R3: The fault flags are sticky. A write to address 0 clears the crystal flag where data bit 0 is 1 and the DCO flag where data bit 1 is 1. Zero bits have no effect.
- R4: When a fault condition is present in the same cycle as a clear, the flag stays set.
- R5: `fll_ref_clk` follows the crystal only when control bit 0 is 1 and the crystal flag is clear. Otherwise it follows the internal oscillator.
- R6: `aux_clk` follows the crystal only when control bit 1 is 1 and the crystal flag is clear. Otherwise it follows the internal oscillator.
- R7: Control sits at address 2 and is written whole. Bit 0 selects the crystal for the FLL reference, bit 1 selects the crystal for the auxiliary clock, and bit 2 enables the interrupt.
- R8: The aggregate flag is set in every cycle in which the crystal or DCO flag is set. A write to address 1 with data bit 0 = 1 clears it, unless a source flag is still set.
- R9: `osc_irq` is the aggregate flag ANDed with control bit 2.
- R10: Each clock output is never enabled from both sources at once. A new source is enabled on its falling edge, after two of its own rising edges. The old source is dropped on its falling edge. A crystal with a live fault is dropped at once.
- R11: The DCO flag is set from the synchronized `dco_fault` input and behaves like the crystal flag for R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and detection clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xt_clk | input | 1 | Crystal oscillator clock |
| ref_clk | input | 1 | Internal reference oscillator clock |
| xt_pin_en | input | 1 | Crystal pin mode enabled (clk domain) |
| dco_fault | input | 1 | Live DCO fault condition |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| fll_ref_clk | output | 1 | Effective FLL reference clock |
| aux_clk | output | 1 | Auxiliary clock |
| xt_flt | output | 1 | Sticky crystal fault flag |
| dco_flt | output | 1 | Sticky DCO fault flag |
| osc_int | output | 1 | Aggregate oscillator fault flag |
| osc_irq | output | 1 | Enabled interrupt |

## Verification
The bench builds the block with its default parameters: TMO_CYC = 8 with a 2-bit address and an 8-bit data path. The crystal runs at a 50 ns period and the internal oscillator at 30 ns. At these rates the missing-edge window is short enough for a crystal stop to trip within a few hundred nanoseconds. The bench also slows the crystal to a 120 ns period, which stays inside the window, and to a 300 ns period, which falls outside it, so both sides of the R2 boundary are exercised. The clock outputs are classified by sampling them against both sources away from every edge. This shows which source each output follows after the R10 handoff.

// File: rtl/xtal_failsafe_clksel.sv
`timescale 1ns/1ps
module xtal_failsafe_clksel #(
  parameter int TMO_CYC = 8,
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xt_clk,
  input  logic          ref_clk,
  input  logic          xt_pin_en,
  input  logic          dco_fault,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          fll_ref_clk,
  output logic          aux_clk,
  output logic          xt_flt,
  output logic          dco_flt,
  output logic          osc_int,
  output logic          osc_irq
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [AW-1:0] A_FLT = AW'(0);
  localparam logic [AW-1:0] A_INT = AW'(1);
  localparam logic [AW-1:0] A_CTL = AW'(2);

  logic [2:0]    xt_s, rf_s;
  logic [1:0]    dco_s;
  logic [CW-1:0] gap;
  logic [2:0]    ctl;
  logic          kill, xrst, rrst;
  logic          xt_rise, rf_rise, timeout, xt_now;
  logic          clr_flt, clr_int;
  logic [1:0]    want, sw_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xt_s  <= '0;
      rf_s  <= '0;
      dco_s <= '0;
    end else begin
      xt_s  <= {xt_s[1:0], xt_clk};
      rf_s  <= {rf_s[1:0], ref_clk};
      dco_s <= {dco_s[0], dco_fault};
    end

  assign xt_rise = xt_s[1] & ~xt_s[2];
  assign rf_rise = rf_s[1] & ~rf_s[2];
  assign timeout = (gap == CW'(TMO_CYC));
  assign xt_now  = ~xt_pin_en | timeout;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  gap <= '0;
    else if (xt_rise)            gap <= '0;
    else if (rf_rise && !timeout) gap <= gap + 1'b1;

  assign clr_flt = wr_en && (wr_addr == A_FLT);
  assign clr_int = wr_en && (wr_addr == A_INT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xt_flt  <= 1'b1;
      dco_flt <= 1'b0;
      osc_int <= 1'b1;
      ctl     <= 3'b011;
      kill    <= 1'b0;
    end else begin
      xt_flt  <= xt_now   | (xt_flt  & ~(clr_flt & wr_data[0]));
      dco_flt <= dco_s[1] | (dco_flt & ~(clr_flt & wr_data[1]));
      osc_int <= xt_flt | dco_flt | (osc_int & ~clr_int);
      if (wr_en && wr_addr == A_CTL) ctl <= wr_data[2:0];
      kill    <= xt_now;
    end

  assign osc_irq = osc_int & ctl[2];
  assign want    = ctl[1:0] & {2{~xt_flt}};
  assign xrst    = ~rst_n | kill;
  assign rrst    = ~rst_n;

  for (genvar g = 0; g < 2; g++) begin : g_sw
    logic xq1, xq2, xen, rq1, rq2, ren;

    always_ff @(posedge xt_clk or posedge xrst)
      if (xrst) begin
        xq1 <= 1'b0;
        xq2 <= 1'b0;
      end else begin
        xq1 <= want[g] & ~ren;
        xq2 <= xq1;
      end

    always_ff @(negedge xt_clk or posedge xrst)
      if (xrst) xen <= 1'b0;
      else      xen <= xq2;

    always_ff @(posedge ref_clk or posedge rrst)
      if (rrst) begin
        rq1 <= 1'b0;
        rq2 <= 1'b0;
      end else begin
        rq1 <= ~want[g] & ~xen;
        rq2 <= rq1;
      end

    always_ff @(negedge ref_clk or posedge rrst)
      if (rrst) ren <= 1'b0;
      else      ren <= rq2;

    assign sw_out[g] = (xt_clk & xen) | (ref_clk & ren);

    a_r10_single_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xen, ren}));
  end

  assign fll_ref_clk = sw_out[0];
  assign aux_clk     = sw_out[1];

  a_r2_fault_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    xt_now |=> xt_flt);
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_flt && !(clr_flt && wr_data[0])) |=> xt_flt);
  a_r4_clear_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (dco_s[1] && clr_flt && wr_data[1]) |=> dco_flt);
  a_r8_aggregate_reraise: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_flt || dco_flt) |=> osc_int);
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_int |-> !osc_irq);
endmodule

// File: tb/xtal_failsafe_clksel_tb_top.sv
`timescale 1ns/1ps
module xtal_failsafe_clksel_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, xt_clk = 1'b0, ref_clk = 1'b0;
  logic       xt_pin_en = 1'b1, dco_fault = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       fll_ref_clk, aux_clk, xt_flt, dco_flt, osc_int, osc_irq;
  logic       xt_run = 1'b1;
  int         xt_half = 25;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  xtal_failsafe_clksel dut_i (
    .clk(clk), .rst_n(rst_n), .xt_clk(xt_clk), .ref_clk(ref_clk),
    .xt_pin_en(xt_pin_en), .dco_fault(dco_fault),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fll_ref_clk(fll_ref_clk), .aux_clk(aux_clk),
    .xt_flt(xt_flt), .dco_flt(dco_flt), .osc_int(osc_int), .osc_irq(osc_irq));

  always #2.5 clk = ~clk;
  initial forever #15 ref_clk = ~ref_clk;
  initial forever begin
    #(xt_half);
    xt_clk = xt_run ? ~xt_clk : 1'b0;
  end

  typedef struct packed {
    logic pin, run, dco, we;
    logic [1:0] addr;
    logic [7:0] data;
    logic e_xt, e_dco, e_int, e_irq, e_fs, e_as;
  } vec_t;
  localparam logic H = 1'b1, L = 1'b0;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{H,H,L,L,2'd0,8'h00, H,L,H,L,L,L},  // flag sticky although crystal runs (R3)
    '{H,H,L,H,2'd1,8'h01, H,L,H,L,L,L},  // aggregate clear loses (R8)
    '{H,H,L,H,2'd0,8'h00, H,L,H,L,L,L},  // zero bits ignored (R3)
    '{H,H,L,H,2'd0,8'h01, L,L,H,L,H,H},  // clear -> back to crystal (R5)
    '{H,H,L,H,2'd1,8'h01, L,L,L,L,H,H},  // aggregate clears (R8)
    '{H,H,L,H,2'd2,8'h04, L,L,L,L,L,L},  // selects off, irq en (R7)
    '{H,H,L,H,2'd2,8'h07, L,L,L,L,H,H},  // R7
    '{H,L,L,L,2'd0,8'h00, H,L,H,H,L,L},  // crystal stops (R2)
    '{H,L,L,H,2'd0,8'h01, H,L,H,H,L,L},  // clear while faulty (R4)
    '{H,H,L,L,2'd0,8'h00, H,L,H,H,L,L},  // resumes, still on ref (R5)
    '{H,H,L,H,2'd0,8'h01, L,L,H,H,H,H},
    '{H,H,L,H,2'd1,8'h01, L,L,L,L,H,H},
    '{H,H,L,H,2'd2,8'h06, L,L,L,L,L,H},  // R6 aux alone on crystal
    '{H,H,H,L,2'd0,8'h00, L,H,H,H,L,H},  // R11
    '{H,H,L,H,2'd0,8'h02, L,L,H,H,L,H},
    '{H,H,L,H,2'd1,8'h01, L,L,L,L,L,H},
    '{L,H,L,L,2'd0,8'h00, H,L,H,H,L,L},  // pin mode off (R2)
    '{H,H,L,H,2'd0,8'h01, L,L,H,H,L,H},
    '{H,H,L,H,2'd2,8'h03, L,L,H,L,H,H},  // irq masked (R9)
    '{H,H,H,H,2'd0,8'h02, L,H,H,L,H,H},  // DCO clear loses (R4)
    '{H,H,L,H,2'd0,8'h03, L,L,H,L,H,H},
    '{H,H,L,H,2'd1,8'h01, L,L,L,L,H,H}
  };

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Classify each output: 1 = crystal, 0 = internal oscillator, 2 = neither (R10)
  task automatic src_of(output int fs, output int as);
    bit fx = 1, fr = 1, ax = 1, ar = 1;
    for (int k = 0; k < 16; k++) begin
      #5;
      fx &= (fll_ref_clk === xt_clk); fr &= (fll_ref_clk === ref_clk);
      ax &= (aux_clk === xt_clk);     ar &= (aux_clk === ref_clk);
    end
    fs = (fx && !fr) ? 1 : (fr && !fx) ? 0 : 2;
    as = (ax && !ar) ? 1 : (ar && !ax) ? 0 : 2;
  endtask

  task automatic settle_and_check(string tag, vec_t v);
    int fs, as;
    repeat (150) @(negedge clk);
    #1;
    chk("R3",  {tag, " xt_flt"},  xt_flt,  v.e_xt);
    chk("R11", {tag, " dco_flt"}, dco_flt, v.e_dco);
    chk("R8",  {tag, " osc_int"}, osc_int, v.e_int);
    chk("R9",  {tag, " osc_irq"}, osc_irq, v.e_irq);
    src_of(fs, as);
    chk("R5",  {tag, " fll src"}, fs, v.e_fs);
    chk("R6",  {tag, " aux src"}, as, v.e_as);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int fs, as;
    repeat (4) @(negedge clk);
    #1;
    // R1: flags and held clocks during reset
    chk("R1", "reset xt_flt", xt_flt, 1);
    chk("R1", "reset dco_flt", dco_flt, 0);
    chk("R1", "reset osc_int", osc_int, 1);
    chk("R1", "reset osc_irq", osc_irq, 0);
    chk("R1", "reset fll low", fll_ref_clk, 0);
    chk("R1", "reset aux low", aux_clk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    settle_and_check("R1 post", '{H,H,L,L,2'd0,8'h00, H,L,H,L,L,L});

    foreach (VEC[i]) begin
      v = VEC[i];
      @(negedge clk);
      xt_pin_en = v.pin; xt_run = v.run; dco_fault = v.dco;
      repeat (40) @(negedge clk);
      if (v.we) wr(v.addr, v.data);
      settle_and_check($sformatf("vec%0d", i), v);
    end

    // R2 boundary: slow crystal with an edge every 4 ref periods stays healthy
    xt_half = 60;
    repeat (400) @(negedge clk);
    settle_and_check("R2 slow ok", '{H,H,L,L,2'd0,8'h00, L,L,L,L,H,H});
    // R2 boundary: 10 ref periods between crystal edges trips the fault
    xt_half = 150;
    repeat (400) @(negedge clk);
    settle_and_check("R2 too slow", '{H,H,L,L,2'd0,8'h00, H,L,H,L,L,L});
    xt_half = 25;
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    settle_and_check("R5 recover", '{H,H,L,L,2'd0,8'h00, L,L,L,L,H,H});

    // R1: reset in the middle of crystal operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "mid reset xt_flt", xt_flt, 1);
    chk("R1", "mid reset osc_int", osc_int, 1);
    chk("R1", "mid reset fll low", fll_ref_clk, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle_and_check("R1 mid post", '{H,H,L,L,2'd0,8'h00, H,L,H,L,L,L});
    src_of(fs, as);
    chk("R7", "ctrl reset aux select", as, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule